// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block is the read side of a parallel NOR flash while a program or erase operation runs. It follows one operation at a time. When a read hits the address that the operation is working on, it replaces the top bit of the returned byte with a status bit. A host can poll that bit until it sees the final value. Reads anywhere else return the contents of a small internal byte array. A completed program writes its datum into that array. A completed erase fills the chosen sectors with all ones.

Each sector can be marked as protected. A program aimed at a protected sector shows status for a fixed number of cycles and then falls back to array reads, leaving the array untouched. The same happens for an erase whose chosen sectors are all protected, with its own window length. An external timing stub supplies a one-cycle completion pulse in place of the embedded algorithm. A level input suspends a running erase. While the erase is suspended, one program operation may run.

Top module: `flashDq7Status`

## Requirements
- R1: Reset is synchronous and active high. After reset `rdData` is 0, `rdValid` is 0 and no operation is pending. Every array byte at address a holds (a*37+11) mod 256. A read sampled with `rdEn` at one clock edge returns `rdData` and `rdValid`=1 after that edge.
- R2: While a program runs, a read of the program address returns bit 7 inverted from bit 7 of the datum and bits 6..0 from the array. Every other address, outside an erase, returns plain array data.
- R3: A completion pulse during a program stores the datum at the program address. Reads issued after that edge return the stored byte unchanged.
- R4: A sector is address bits [ADDR_W-1 -: SECT_W]. While an erase runs unsuspended, a read inside a sector that is chosen and unprotected returns bit 7 = 0 and bits 6..0 from the array. Other sectors return array data.
- R5: While `suspend` is high during an erase, those same reads return bit 7 = 1. A completion pulse has no effect while suspended.
- R6: During a suspended erase a program command is accepted and reports as in R2. Reads of the erased sectors keep bit 7 = 1. Its completion stores the datum and returns to the suspended erase.
- R7: A completion pulse during an unsuspended erase sets every byte of the chosen, unprotected sectors to 8'hFF. Chosen protected sectors keep their contents.
- R8: A program command (`cmdOp`=0) to a protected sector reports R2 status for exactly PROG_PROT_CYC reads after the command edge and then returns array reads. The array is not written, even if a completion pulse arrives inside the window.
- R9: An erase command (`cmdOp`=1) whose chosen sectors are all protected, or which chooses none, reports bit 7 = 0 in the chosen sectors for exactly ERASE_PROT_CYC reads. It then returns array reads and erases nothing.
- R10: A command that arrives while an operation is pending is ignored. The one exception is a program during a suspended erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | One-cycle pulse marking the final write-enable edge of a command |
| cmdOp | input | 1 | 0 = program, 1 = erase |
| cmdAddr | input | ADDR_W | Program address |
| cmdData | input | 8 | Datum to program |
| eraseSel | input | 2**SECT_W | Sectors chosen for erase |
| sectProt | input | 2**SECT_W | Per-sector protect flags |
| suspend | input | 1 | Erase suspend level |
| opDone | input | 1 | Completion pulse from the timing stub |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read byte, status or array |
| rdValid | output | 1 | High the cycle after a sampled read |

## Verification
A read takes one registered stage: the byte for a read sampled at edge k is on `rdData` after edge k. Status follows the operation state that was in force just before that edge. The first read issued after a command edge therefore already reports status, and a read after a completion edge already shows the new array value. The bench drives every stimulus at a falling edge, lets one rising edge pass and compares at the next falling edge. Inside a protection window the read at position N (counted from the command edge) is compared against status for N up to the window length, and against array data just beyond it.

// File: rtl/flashDq7Pkg.sv
package flashDq7Pkg;

  localparam logic OP_PROG  = 1'b0;
  localparam logic OP_ERASE = 1'b1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_PPROT,
    S_ERASE,
    S_EPROT,
    S_SPROG
  } ctlState_e;

  typedef struct packed {
    logic latchProg;
    logic latchErase;
    logic commitProg;
    logic commitErase;
    logic progActive;
    logic eraseActive;
    logic eraseBit;
  } ctlStrobe_t;

endpackage

// File: rtl/flashDq7Ctrl.sv
module flashDq7Ctrl
  import flashDq7Pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int SECT_W         = 2,
  parameter int PROG_PROT_CYC  = 50,
  parameter int ERASE_PROT_CYC = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic                 cmdOp,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [2**SECT_W-1:0] eraseSel,
  input  logic [2**SECT_W-1:0] sectProt,
  input  logic                 suspend,
  input  logic                 opDone,
  output ctlStrobe_t           strb,
  output ctlState_e            state
);

  localparam int MAX_CYC = (PROG_PROT_CYC > ERASE_PROT_CYC) ? PROG_PROT_CYC : ERASE_PROT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_PROT_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_PROT_CYC - 1);

  ctlState_e        nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             retErase, nxtRet;
  logic             cmdProt, allProt, progCmd, eraseCmd, winDone;

  assign cmdProt  = sectProt[cmdAddr[ADDR_W-1 -: SECT_W]];
  assign allProt  = ((eraseSel & ~sectProt) == '0);
  assign progCmd  = cmdValid && (cmdOp == OP_PROG);
  assign eraseCmd = cmdValid && (cmdOp == OP_ERASE);
  assign winDone  = (cnt == '0);

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    nxtRet   = retErase;
    strb     = '0;
    unique case (state)
      S_IDLE: begin
        if (progCmd) begin
          strb.latchProg = 1'b1;
          nxtRet         = 1'b0;
          if (cmdProt) begin
            nxtState = S_PPROT;
            nxtCnt   = PROG_LOAD;
          end else begin
            nxtState = S_PROG;
          end
        end else if (eraseCmd) begin
          strb.latchErase = 1'b1;
          if (allProt) begin
            nxtState = S_EPROT;
            nxtCnt   = ERASE_LOAD;
          end else begin
            nxtState = S_ERASE;
          end
        end
      end
      S_PROG: begin
        if (opDone) begin
          strb.commitProg = 1'b1;
          nxtState        = S_IDLE;
        end
      end
      S_PPROT: begin
        if (winDone) nxtState = retErase ? S_ERASE : S_IDLE;
        else         nxtCnt   = cnt - 1'b1;
      end
      S_ERASE: begin
        if (suspend) begin
          if (progCmd) begin
            strb.latchProg = 1'b1;
            if (cmdProt) begin
              nxtState = S_PPROT;
              nxtCnt   = PROG_LOAD;
              nxtRet   = 1'b1;
            end else begin
              nxtState = S_SPROG;
            end
          end
        end else if (opDone) begin
          strb.commitErase = 1'b1;
          nxtState         = S_IDLE;
        end
      end
      S_EPROT: begin
        if (winDone) nxtState = S_IDLE;
        else         nxtCnt   = cnt - 1'b1;
      end
      S_SPROG: begin
        if (opDone) begin
          strb.commitProg = 1'b1;
          nxtState        = S_ERASE;
        end
      end
      default: nxtState = S_IDLE;
    endcase

    strb.progActive  = (state == S_PROG) || (state == S_PPROT) || (state == S_SPROG);
    strb.eraseActive = (state == S_ERASE) || (state == S_EPROT) || (state == S_SPROG) ||
                       ((state == S_PPROT) && retErase);
    strb.eraseBit    = ((state == S_ERASE) && suspend) || (state == S_SPROG) ||
                       ((state == S_PPROT) && retErase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      retErase <= 1'b0;
    end else begin
      state    <= nxtState;
      cnt      <= nxtCnt;
      retErase <= nxtRet;
    end
  end

endmodule

// File: rtl/flashDq7Dp.sv
module flashDq7Dp
  import flashDq7Pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobe_t           strb,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [DATA_W-1:0]    cmdData,
  input  logic [2**SECT_W-1:0] eraseSel,
  input  logic [2**SECT_W-1:0] sectProt,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic [ADDR_W-1:0]    progAddr,
  output logic                 progMsb,
  output logic [2**SECT_W-1:0] eraseMask
);

  localparam int DEPTH  = 2**ADDR_W;
  localparam int NSECT  = 2**SECT_W;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] progData;
  logic [DATA_W-1:0] rdMux;
  logic [NSECT-1:0]  effSel;
  logic [DEPTH-1:0]  eraseHitVec;
  logic              progHit, eraseHit;

  function automatic logic [DATA_W-1:0] initByte(input int a);
    return DATA_W'(a * 37 + 11);
  endfunction

  assign effSel  = eraseSel & ~sectProt;
  assign progMsb = progData[MSB];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gEraseHit
      localparam int SECT_OF = g / (DEPTH / NSECT);
      assign eraseHitVec[g] = strb.commitErase && eraseMask[SECT_OF];
    end
  endgenerate

  always_comb begin
    progHit  = strb.progActive && (rdAddr == progAddr);
    eraseHit = strb.eraseActive && eraseMask[rdAddr[ADDR_W-1 -: SECT_W]];
    rdMux    = mem[rdAddr];
    if (progHit)       rdMux[MSB] = ~progData[MSB];
    else if (eraseHit) rdMux[MSB] = strb.eraseBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initByte(i);
      progAddr  <= '0;
      progData  <= '0;
      eraseMask <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (strb.latchProg) begin
        progAddr <= cmdAddr;
        progData <= cmdData;
      end
      if (strb.latchErase) eraseMask <= (effSel == '0) ? eraseSel : effSel;
      if (strb.commitProg) mem[progAddr] <= progData;
      for (int i = 0; i < DEPTH; i++) begin
        if (eraseHitVec[i]) mem[i] <= '1;
      end
      rdValid <= rdEn;
      if (rdEn) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/flashDq7Status.sv
module flashDq7Status
  import flashDq7Pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int SECT_W         = 2,
  parameter int PROG_PROT_CYC  = 50,
  parameter int ERASE_PROT_CYC = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic                 cmdOp,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [7:0]           cmdData,
  input  logic [2**SECT_W-1:0] eraseSel,
  input  logic [2**SECT_W-1:0] sectProt,
  input  logic                 suspend,
  input  logic                 opDone,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [7:0]           rdData,
  output logic                 rdValid
);

  ctlStrobe_t           strb;
  ctlState_e            ctlState;
  logic [ADDR_W-1:0]    progAddr;
  logic                 progMsb;
  logic [2**SECT_W-1:0] eraseMask;

  flashDq7Ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .PROG_PROT_CYC(PROG_PROT_CYC), .ERASE_PROT_CYC(ERASE_PROT_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .eraseSel(eraseSel), .sectProt(sectProt), .suspend(suspend), .opDone(opDone),
    .strb(strb), .state(ctlState)
  );

  flashDq7Dp #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(8)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .eraseSel(eraseSel), .sectProt(sectProt), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .progAddr(progAddr), .progMsb(progMsb),
    .eraseMask(eraseMask)
  );

endmodule

// File: rtl/flashDq7Status_chk.sv
module flashDq7Status_chk
  import flashDq7Pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int SECT_W         = 2,
  parameter int PROG_PROT_CYC  = 50,
  parameter int ERASE_PROT_CYC = 5000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rdEn,
  input logic                 rdValid,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic [7:0]           rdData,
  input logic                 suspend,
  input logic                 cmdValid,
  input ctlStrobe_t           strb,
  input ctlState_e            ctlState,
  input logic [ADDR_W-1:0]    progAddr,
  input logic                 progMsb,
  input logic [2**SECT_W-1:0] eraseMask
);

  int unsigned ppDwell, epDwell;

  always_ff @(posedge clk) begin
    if (rst) begin
      ppDwell <= 0;
      epDwell <= 0;
    end else begin
      ppDwell <= (ctlState == S_PPROT) ? ppDwell + 1 : 0;
      epDwell <= (ctlState == S_EPROT) ? epDwell + 1 : 0;
    end
  end

  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdValid);

  // R1
  read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> !rdValid);

  // R2
  prog_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && strb.progActive && rdAddr == progAddr) |=> (rdData[7] != $past(progMsb)));

  // R4
  erase_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !(strb.progActive && rdAddr == progAddr) && strb.eraseActive && !strb.eraseBit &&
     eraseMask[rdAddr[ADDR_W-1 -: SECT_W]]) |=> (rdData[7] == 1'b0));

  // R5
  no_commit_suspended_chk: assert property (@(posedge clk) disable iff (rst)
    strb.commitErase |-> !suspend);

  // R8
  prog_window_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctlState == S_PPROT) |-> ($past(ppDwell) == PROG_PROT_CYC - 1));

  // R9
  erase_window_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctlState == S_EPROT) |-> ($past(epDwell) == ERASE_PROT_CYC - 1));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ctlState == S_PROG && cmdValid) |=> (ctlState == S_PROG || ctlState == S_IDLE));

  // R3
  single_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.latchProg, strb.latchErase, strb.commitProg, strb.commitErase}));

endmodule

bind flashDq7Status flashDq7Status_chk #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W),
  .PROG_PROT_CYC(PROG_PROT_CYC), .ERASE_PROT_CYC(ERASE_PROT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .rdEn(rdEn), .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData),
  .suspend(suspend), .cmdValid(cmdValid), .strb(strb), .ctlState(ctlState),
  .progAddr(progAddr), .progMsb(progMsb), .eraseMask(eraseMask)
);

// File: tb/flashDq7Status_bench.sv
module flashDq7Status_bench;

  localparam int AW = 6;
  localparam int SW = 2;
  localparam int PP = 5;
  localparam int EP = 12;

  logic       clk = 0;
  logic       rst = 1;
  logic       cmdValid = 0, cmdOp = 0, suspend = 0, opDone = 0, rdEn = 0;
  logic [5:0] cmdAddr = 0, rdAddr = 0;
  logic [7:0] cmdData = 0;
  logic [3:0] eraseSel = 0, sectProt = 0;
  logic [7:0] rdData;
  logic       rdValid;

  int vectors = 0;
  int fails = 0;

  logic [7:0] mdl [64];
  logic       bProg = 0, bErase = 0, bEb = 0;
  logic [5:0] bPA = 0;
  logic [7:0] bPD = 0;
  logic [3:0] bMask = 0;

  flashDq7Status #(.ADDR_W(AW), .SECT_W(SW), .PROG_PROT_CYC(PP), .ERASE_PROT_CYC(EP))
    u_flashDq7Status (
      .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
      .cmdData(cmdData), .eraseSel(eraseSel), .sectProt(sectProt), .suspend(suspend),
      .opDone(opDone), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid));

  always #10 clk = ~clk;

  function automatic logic [7:0] expByte(input int a);
    logic [7:0] v = mdl[a];
    if (bProg && a == int'(bPA))          v[7] = ~bPD[7];
    else if (bErase && bMask[a / 16])     v[7] = bEb;
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, input string req);
    logic [7:0] e = expByte(a);
    rdEn = 1; rdAddr = 6'(a);
    @(negedge clk);
    rdEn = 0;
    check(req, rdData, e);
    if (rdValid !== 1'b1) begin
      vectors++; fails++;
      $display("FAIL %s: rdValid got %b expected 1", req, rdValid);
    end
  endtask

  task automatic rdRaw(input int a, input logic [7:0] e, input string req);
    rdEn = 1; rdAddr = 6'(a);
    @(negedge clk);
    rdEn = 0;
    check(req, rdData, e);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 64; a++) rd(a, req);
  endtask

  task automatic cmd(input logic op, input int a, input logic [7:0] d, input logic [3:0] sel);
    cmdValid = 1; cmdOp = op; cmdAddr = 6'(a); cmdData = d; eraseSel = sel;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic pulseDone();
    opDone = 1;
    @(negedge clk);
    opDone = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) mdl[a] = 8'(a * 37 + 11);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset outputs
    check("R1", rdData, 8'h00);
    check("R1", {7'b0, rdValid}, 8'h00);
    sweep("R1");

    // R2 / R3 program with datum bit 7 clear and set
    cmd(1'b0, 5, 8'h3C, 4'b0000);
    bProg = 1; bPA = 5; bPD = 8'h3C;
    rd(5, "R2"); rd(6, "R2"); rd(5, "R2");
    // R10 erase command while busy is ignored
    cmd(1'b1, 0, 8'h00, 4'b0001);
    rd(5, "R10"); rd(1, "R10");
    pulseDone();
    mdl[5] = 8'h3C; bProg = 0;
    rd(5, "R3"); rd(1, "R10");

    cmd(1'b0, 40, 8'hC3, 4'b0000);
    bProg = 1; bPA = 40; bPD = 8'hC3;
    rd(40, "R2"); rd(41, "R2");
    pulseDone();
    mdl[40] = 8'hC3; bProg = 0;
    rd(40, "R3");

    // R8 program to protected sector 2, completion pulse inside window ignored
    sectProt = 4'b0100;
    cmd(1'b0, 33, 8'h00, 4'b0000);
    bProg = 1; bPA = 33; bPD = 8'h00;
    rd(33, "R8"); rd(33, "R8");
    pulseDone();
    rd(33, "R8"); rd(33, "R8");
    bProg = 0;
    rd(33, "R8"); rd(34, "R8");

    // R4 erase of sectors 0,1,2 with sector 2 protected
    cmd(1'b1, 0, 8'h00, 4'b0111);
    bErase = 1; bMask = 4'b0011; bEb = 0;
    sweep("R4");
    // R5 suspend flips the status bit; completion ignored
    suspend = 1; bEb = 1;
    sweep("R5");
    pulseDone();
    sweep("R5");
    // R6 program while suspended
    cmd(1'b0, 50, 8'h12, 4'b0000);
    bProg = 1; bPA = 50; bPD = 8'h12;
    rd(50, "R6"); rd(3, "R6"); rd(20, "R6");
    pulseDone();
    mdl[50] = 8'h12; bProg = 0;
    rd(50, "R6"); rd(3, "R6");
    suspend = 0; bEb = 0;
    rd(3, "R4"); rd(17, "R4");
    // R7 completion erases unprotected chosen sectors
    pulseDone();
    for (int a = 0; a < 32; a++) mdl[a] = 8'hFF;
    bErase = 0;
    sweep("R7");

    // R9 erase where every chosen sector is protected
    cmd(1'b1, 0, 8'h00, 4'b0100);
    bErase = 1; bMask = 4'b0100; bEb = 0;
    for (int k = 0; k < EP; k++) rd(32 + k, "R9");
    bErase = 0;
    rd(32 + EP, "R9");
    for (int a = 32; a < 48; a++) rd(a, "R9");
    rdRaw(5, 8'hFF, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule